// File: doc/BRIEF.md
# L4 Port Range Match Bank

This block holds a small set of programmable port-range checkers and classifies every packet header presented to it against all of them at once. Each checker keeps an inclusive window of 16-bit port numbers, a choice of whether the source or the destination port is tested, and four qualifier enables. Two of the enables select the IPv4 and IPv6 network layers. The other two select the TCP and UDP transports. A header passes a checker only when its network layer and its transport are both enabled there and the chosen port lies inside the window.

The result is a fixed 16-bit vector with one bit per checker. Bit i belongs to checker i, and bits with no checker behind them stay zero. The vector is meant to be used directly as a key element of a classification lookup. Software programs the checkers through a simple write port that takes an index, a valid flag and the full field set. The vector comes out of a register one cycle after the header is accepted, together with a valid flag.

Top module: `l4rng_match_bank`

## Requirements
- R1: After synchronous reset, `match_vld` and `match_vec` are 0 and every checker is invalid, so it reports 0 until it is written.
- R2: `match_vld` is `hdr_vld` delayed by one clock. `match_vec` is all-zero in every cycle where `match_vld` is 0.
- R3: Bit i of `match_vec` is the result of checker i. Bits at and above `NUM_RANGES` are always 0.
- R4: A checker's port test is min <= port <= max, inclusive at both ends. A checker with min greater than max never matches.
- R5: When a checker's `cfg_src` flag is 1, it tests `hdr_sport`. When the flag is 0, it tests `hdr_dport`. Exactly one of the two ports is used.
- R6: `hdr_l3` encoding is 2'b01 for IPv4 and 2'b10 for IPv6. A checker matches only when the enable for the header's network layer is set.
- R7: `hdr_l4` encoding is 2'b01 for TCP and 2'b10 for UDP. A checker matches only when the enable for the header's transport is set.
- R8: A header whose `hdr_l3` is neither IPv4 nor IPv6, or whose `hdr_l4` is neither TCP nor UDP, produces an all-zero vector.
- R9: A write with `cfg_valid` at 0 makes the checker invalid. An invalid checker reports 0 whatever the header holds.
- R10: A write whose `cfg_idx` is `NUM_RANGES` or higher changes no checker.
- R11: A write takes effect at the clock edge that accepts it. A header accepted at that same edge is classified with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one checker |
| cfg_idx | input | 4 | Index of the checker to write |
| cfg_valid | input | 1 | 1 enables the checker, 0 invalidates it |
| cfg_min | input | 16 | Lower bound of the port window |
| cfg_max | input | 16 | Upper bound of the port window |
| cfg_src | input | 1 | 1 tests the source port, 0 tests the destination port |
| cfg_en_v4 | input | 1 | Match IPv4 headers |
| cfg_en_v6 | input | 1 | Match IPv6 headers |
| cfg_en_tcp | input | 1 | Match TCP headers |
| cfg_en_udp | input | 1 | Match UDP headers |
| hdr_vld | input | 1 | Header fields are valid this cycle |
| hdr_l3 | input | 2 | Network layer: 01 IPv4, 10 IPv6, other values none |
| hdr_l4 | input | 2 | Transport: 01 TCP, 10 UDP, other values none |
| hdr_sport | input | 16 | Source port |
| hdr_dport | input | 16 | Destination port |
| match_vld | output | 1 | `match_vec` is valid |
| match_vec | output | 16 | One result bit per checker |

## Verification
The assertions assume that the header fields and the write fields are stable, known values around each sampling edge. They also assume that `NUM_RANGES` does not exceed 16, which leaves the out-of-range write check meaningful only for smaller banks. The bench drives every input on the falling edge, so all values are settled at the rising edge. It uses a bank of 12 checkers, so that out-of-range indexes and the unused key bits are both reachable, and it exercises every header encoding, including the undefined codes 00 and 11.

// File: rtl/l4rng_pkg.sv
package l4rng_pkg;

    localparam int KEY_W  = 16;
    localparam int PORT_W = 16;
    localparam int IDX_W  = $clog2(KEY_W);

    typedef enum logic [1:0] {
        L3_NONE = 2'b00,
        L3_V4   = 2'b01,
        L3_V6   = 2'b10,
        L3_RSVD = 2'b11
    } l3_kind_e;

    typedef enum logic [1:0] {
        L4_NONE = 2'b00,
        L4_TCP  = 2'b01,
        L4_UDP  = 2'b10,
        L4_RSVD = 2'b11
    } l4_kind_e;

    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] lo;
        logic [PORT_W-1:0] hi;
        logic              use_src;
        logic              en_v4;
        logic              en_v6;
        logic              en_tcp;
        logic              en_udp;
    } rng_cfg_t;

    typedef struct packed {
        l3_kind_e          l3;
        l4_kind_e          l4;
        logic [PORT_W-1:0] sport;
        logic [PORT_W-1:0] dport;
    } hdr_t;

    function automatic logic port_inside(logic [PORT_W-1:0] p,
                                         logic [PORT_W-1:0] lo,
                                         logic [PORT_W-1:0] hi);
        return (p >= lo) && (p <= hi);
    endfunction

endpackage

// File: rtl/l4rng_cfg_bank.sv
module l4rng_cfg_bank
    import l4rng_pkg::*;
#(
    parameter int NUM_RANGES = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 idx,
    input  rng_cfg_t                         wdata,
    output rng_cfg_t [NUM_RANGES-1:0]        cfg_q
);

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                cfg_q[i] <= wdata;
            end
        end

        // R9: a write lands its valid flag and direction in the addressed entry
        a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
            (we && idx == IDX_W'(i)) |=>
                (cfg_q[i].valid == $past(wdata.valid) &&
                 cfg_q[i].use_src == $past(wdata.use_src)));
    end

    // R10: writes beyond the bank leave every entry untouched
    a_r10_oob_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && int'(idx) >= NUM_RANGES) |=> $stable(cfg_q));

endmodule

// File: rtl/l4rng_cell.sv
module l4rng_cell
    import l4rng_pkg::*;
(
    input  rng_cfg_t cfg,
    input  hdr_t     hdr,
    output logic     hit
);

    logic              l3_ok;
    logic              l4_ok;
    logic [PORT_W-1:0] port;

    always_comb begin
        l3_ok = (hdr.l3 == L3_V4 && cfg.en_v4) || (hdr.l3 == L3_V6 && cfg.en_v6);
        l4_ok = (hdr.l4 == L4_TCP && cfg.en_tcp) || (hdr.l4 == L4_UDP && cfg.en_udp);
        port  = cfg.use_src ? hdr.sport : hdr.dport;
        hit   = cfg.valid && l3_ok && l4_ok && port_inside(port, cfg.lo, cfg.hi);
    end

endmodule

// File: rtl/l4rng_match_bank.sv
module l4rng_match_bank
    import l4rng_pkg::*;
#(
    parameter int NUM_RANGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_idx,
    input  logic        cfg_valid,
    input  logic [15:0] cfg_min,
    input  logic [15:0] cfg_max,
    input  logic        cfg_src,
    input  logic        cfg_en_v4,
    input  logic        cfg_en_v6,
    input  logic        cfg_en_tcp,
    input  logic        cfg_en_udp,
    input  logic        hdr_vld,
    input  logic [1:0]  hdr_l3,
    input  logic [1:0]  hdr_l4,
    input  logic [15:0] hdr_sport,
    input  logic [15:0] hdr_dport,
    output logic        match_vld,
    output logic [15:0] match_vec
);

    rng_cfg_t                  wdata;
    rng_cfg_t [NUM_RANGES-1:0] cfg_q;
    hdr_t                      hdr;
    logic [KEY_W-1:0]          hit_vec;

    always_comb begin
        wdata.valid   = cfg_valid;
        wdata.lo      = cfg_min;
        wdata.hi      = cfg_max;
        wdata.use_src = cfg_src;
        wdata.en_v4   = cfg_en_v4;
        wdata.en_v6   = cfg_en_v6;
        wdata.en_tcp  = cfg_en_tcp;
        wdata.en_udp  = cfg_en_udp;
        hdr.l3        = l3_kind_e'(hdr_l3);
        hdr.l4        = l4_kind_e'(hdr_l4);
        hdr.sport     = hdr_sport;
        hdr.dport     = hdr_dport;
    end

    l4rng_cfg_bank #(.NUM_RANGES(NUM_RANGES)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (wdata),
        .cfg_q (cfg_q)
    );

    for (genvar i = 0; i < KEY_W; i++) begin : g_key
        if (i < NUM_RANGES) begin : g_cell
            l4rng_cell u_cell (
                .cfg (cfg_q[i]),
                .hdr (hdr),
                .hit (hit_vec[i])
            );

            // R9: an invalid entry never raises its bit
            a_r9_invalid_zero: assert property (@(posedge clk) disable iff (rst)
                (hdr_vld && !cfg_q[i].valid) |=> !match_vec[i]);

            // R4: an inverted window never raises its bit
            a_r4_inverted_window: assert property (@(posedge clk) disable iff (rst)
                (hdr_vld && cfg_q[i].lo > cfg_q[i].hi) |=> !match_vec[i]);
        end else begin : g_pad
            assign hit_vec[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_vld <= 1'b0;
            match_vec <= '0;
        end else begin
            match_vld <= hdr_vld;
            match_vec <= hdr_vld ? hit_vec : '0;
        end
    end

    // R2: one cycle from header to result
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        hdr_vld |=> match_vld);

    // R2: no header, no result
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !hdr_vld |=> (!match_vld && match_vec == '0));

    // R8: unknown transport gives an empty vector
    a_r8_bad_l4: assert property (@(posedge clk) disable iff (rst)
        (hdr_vld && !(hdr_l4 == 2'b01 || hdr_l4 == 2'b10)) |=> match_vec == '0);

    // R8: unknown network layer gives an empty vector
    a_r8_bad_l3: assert property (@(posedge clk) disable iff (rst)
        (hdr_vld && !(hdr_l3 == 2'b01 || hdr_l3 == 2'b10)) |=> match_vec == '0);

endmodule

// File: tb/l4rng_match_bank_test.sv
module l4rng_match_bank_test;

    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic        cfg_valid;
    logic [15:0] cfg_min;
    logic [15:0] cfg_max;
    logic        cfg_src;
    logic        cfg_en_v4;
    logic        cfg_en_v6;
    logic        cfg_en_tcp;
    logic        cfg_en_udp;
    logic        hdr_vld;
    logic [1:0]  hdr_l3;
    logic [1:0]  hdr_l4;
    logic [15:0] hdr_sport;
    logic [15:0] hdr_dport;
    logic        match_vld;
    logic [15:0] match_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    l4rng_match_bank #(.NUM_RANGES(N)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_min(cfg_min), .cfg_max(cfg_max), .cfg_src(cfg_src),
        .cfg_en_v4(cfg_en_v4), .cfg_en_v6(cfg_en_v6),
        .cfg_en_tcp(cfg_en_tcp), .cfg_en_udp(cfg_en_udp),
        .hdr_vld(hdr_vld), .hdr_l3(hdr_l3), .hdr_l4(hdr_l4),
        .hdr_sport(hdr_sport), .hdr_dport(hdr_dport),
        .match_vld(match_vld), .match_vec(match_vec)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int idx, input bit v, input int lo, input int hi,
                           input bit src, input bit v4, input bit v6, input bit tcp, input bit udp);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v;
        cfg_min = 16'(lo); cfg_max = 16'(hi); cfg_src = src;
        cfg_en_v4 = v4; cfg_en_v6 = v6; cfg_en_tcp = tcp; cfg_en_udp = udp;
    endtask

    task automatic write(input int idx, input bit v, input int lo, input int hi,
                         input bit src, input bit v4, input bit v6, input bit tcp, input bit udp);
        @(negedge clk);
        set_cfg(idx, v, lo, hi, src, v4, v6, tcp, udp);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one header, return result sampled one cycle later
    task automatic send(input logic [1:0] l3, input logic [1:0] l4, input int sp, input int dp,
                        input logic [15:0] exp, input string req);
        @(negedge clk);
        hdr_vld = 1'b1; hdr_l3 = l3; hdr_l4 = l4;
        hdr_sport = 16'(sp); hdr_dport = 16'(dp);
        @(negedge clk);
        hdr_vld = 1'b0;
        check({15'b0, match_vld}, 16'h1, {req, " R2 valid"});
        check(match_vec, exp, req);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 1'b0; hdr_vld = 1'b0; hdr_l3 = 2'b0; hdr_l4 = 2'b0;
        hdr_sport = '0; hdr_dport = '0;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0); cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({15'b0, match_vld}, 16'h0, "R1 vld");
        check(match_vec, 16'h0, "R1 vec");
        send(2'b01, 2'b01, 80, 80, 16'h0000, "R1 unwritten");
    endtask

    task automatic t_window();
        write(0, 1, 100, 200, 0, 1, 1, 1, 1);
        write(3, 1, 150, 150, 0, 1, 1, 1, 1);
        write(5, 1, 300, 200, 0, 1, 1, 1, 1);
        write(7, 1, 0, 65535, 1, 1, 1, 1, 1);
        send(2'b01, 2'b01, 5, 100, 16'h0081, "R4 low edge R3");
        send(2'b01, 2'b01, 5, 150, 16'h0089, "R4 single port R3");
        send(2'b01, 2'b01, 5, 200, 16'h0081, "R4 high edge");
        send(2'b01, 2'b01, 5, 201, 16'h0080, "R4 above");
        send(2'b01, 2'b01, 5, 99,  16'h0080, "R4 below");
    endtask

    task automatic t_idle();
        send(2'b01, 2'b01, 5, 100, 16'h0081, "R2 before idle");
        @(negedge clk);
        check({15'b0, match_vld}, 16'h0, "R2 idle vld");
        check(match_vec, 16'h0, "R2 idle vec");
    endtask

    task automatic t_direction();
        write(1, 1, 1000, 2000, 1, 1, 1, 1, 1);
        send(2'b01, 2'b01, 1500, 50, 16'h0082, "R5 source");
        send(2'b01, 2'b01, 50, 1500, 16'h0080, "R5 not destination");
    endtask

    task automatic t_l3();
        write(2, 1, 0, 65535, 0, 1, 0, 1, 1);
        write(4, 1, 0, 65535, 0, 0, 1, 1, 1);
        send(2'b01, 2'b01, 5, 10, 16'h0084, "R6 ipv4");
        send(2'b10, 2'b10, 5, 10, 16'h0090, "R6 ipv6");
    endtask

    task automatic t_l4();
        write(6, 1, 0, 65535, 1, 1, 1, 0, 1);
        write(8, 1, 0, 65535, 1, 1, 1, 1, 0);
        send(2'b01, 2'b10, 5, 10, 16'h00C4, "R7 udp");
        send(2'b01, 2'b01, 5, 10, 16'h0184, "R7 tcp");
    endtask

    task automatic t_bad_proto();
        send(2'b01, 2'b00, 5, 10, 16'h0000, "R8 l4 none");
        send(2'b01, 2'b11, 5, 10, 16'h0000, "R8 l4 rsvd");
        send(2'b00, 2'b01, 5, 10, 16'h0000, "R8 l3 none");
        send(2'b11, 2'b10, 5, 10, 16'h0000, "R8 l3 rsvd");
    endtask

    task automatic t_invalidate();
        write(7, 0, 0, 65535, 1, 1, 1, 1, 1);
        send(2'b01, 2'b01, 5, 10, 16'h0104, "R9 cleared");
    endtask

    task automatic t_oob();
        write(12, 1, 0, 65535, 0, 1, 1, 1, 1);
        write(15, 1, 0, 65535, 0, 1, 1, 1, 1);
        send(2'b01, 2'b01, 5, 10, 16'h0104, "R10 ignored");
        write(11, 1, 0, 65535, 0, 1, 1, 1, 1);
        send(2'b01, 2'b01, 5, 10, 16'h0904, "R3 top entry upper bits zero");
    endtask

    task automatic t_same_edge();
        @(negedge clk);
        set_cfg(11, 0, 0, 0, 0, 0, 0, 0, 0);
        hdr_vld = 1'b1; hdr_l3 = 2'b01; hdr_l4 = 2'b01; hdr_sport = 16'd5; hdr_dport = 16'd10;
        @(negedge clk);
        hdr_vld = 1'b0; cfg_we = 1'b0;
        check(match_vec, 16'h0904, "R11 old settings");
        send(2'b01, 2'b01, 5, 10, 16'h0104, "R11 new settings");
    endtask

    initial begin
        t_reset();
        t_window();
        t_idle();
        t_direction();
        t_l3();
        t_l4();
        t_bad_proto();
        t_invalidate();
        t_oob();
        t_same_edge();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, all requirements, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule